// File: doc/BRIEF.md
# Floating-Point Invalid-Operand Detector

This block decides, for one single-precision operation, whether the invalid-arithmetic-operand exception applies. It takes an operation code and one or two 32-bit IEEE binary32 operands. It returns four things: an invalid flag, a selector and value that tell the datapath what to write instead of the normal result, and the compare condition codes. It does not compute the normal result and does not detect overflow, underflow, precision or divide-by-zero.

The decision logic is combinational. All outputs are registered and appear one clock after an accepted request. A sticky summary flag records every detection until software-side logic clears it. The sticky flag is a two-state machine. In state `STK_IDLE` the flag is low. Transition `SET_ON_HIT` moves it to `STK_SET` on any accepted invalid operation. Transition `CLEAR` returns it to `STK_IDLE` when a clear arrives in a cycle with no new detection. In every other case the state holds.

Top module: `fpinv_top`

## Requirements
- R1: Operation codes are add 0, subtract 1, multiply 2, divide 3, square root 4, remainder 5, ordered compare 6, unordered compare 7, float-to-integer 8. All outputs are registered one clock after `valid_i`, and `valid_o` is high for exactly that cycle. No output and no sticky state changes when `valid_i` is low.
- R2: For add, subtract, multiply, divide, remainder and square root, an SNaN operand raises invalid. The selector is 2 (quieted SNaN) and the value is the first SNaN operand (a before b) with fraction bit 22 set.
- R3: In the absence of NaNs, add with infinities of opposite sign and subtract with infinities of equal sign raise invalid. The selector is 1 and the value is 0xFFC00000.
- R4: In the absence of NaNs, multiply of infinity by zero in either order, divide of infinity by infinity, and divide of zero by zero raise invalid with selector 1. A subnormal counts as nonzero.
- R5: Square root of a negative nonzero non-NaN operand, including negative infinity, raises invalid with selector 1. Square root of negative zero does not raise invalid. Operand b is ignored.
- R6: In the absence of NaNs, remainder with a zero divisor (b) or an infinite dividend (a) raises invalid with selector 1, and the condition codes {C3,C2,C0} are 000.
- R7: Ordered compare with any NaN raises invalid, gives codes 111 and selector 0. With no NaN the codes are 000 for a>b, 001 for a<b and 100 for equal, and +0 equals -0.
- R8: Unordered compare with any NaN gives codes 111 and raises invalid only if an operand is an SNaN.
- R9: A QNaN operand with no SNaN raises no invalid for the arithmetic operations (codes 0 to 5). The selector is then 0, and selector 0 always carries value 0.
- R10: Float-to-integer raises invalid with selector 3 and value 0x80000000 when a is a NaN or infinity, or when |a| >= 2^31. The exception is exactly -2^31, which is valid. Operand b is ignored.
- R11: The sticky flag is set by every accepted invalid result and holds until `sticky_clr_i`. A clear in the same cycle as a new detection leaves it set.
- R12: Reset clears every output. Operation codes 9 to 15 never raise invalid and give selector 0 and codes 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Request valid |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| sticky_clr_i | input | 1 | Clear the sticky flag |
| valid_o | output | 1 | Result valid |
| invalid_o | output | 1 | Invalid exception for this operation |
| ovr_o | output | 2 | Result override: 0 none, 1 QNaN indefinite, 2 quieted SNaN, 3 integer indefinite |
| ovr_val_o | output | 32 | Override value |
| cc_o | output | 3 | Condition codes {C3,C2,C0} |
| sticky_o | output | 1 | Sticky invalid flag |

## Verification
The bench targets the following corner cases:
- Signed-infinity pairs, where a swapped sign rule would flag the legal case and pass the illegal one.
- Negative zero under square root, which a plain sign test would reject.
- A QNaN in arithmetic versus in the two compare flavours and conversion, where a wrong trigger set would raise or miss invalid.
- A subnormal multiplied by infinity, which a too-loose zero test would flag.
- The conversion limits 2^31, -2^31 and 2^31-128, where an off-by-one exponent bound would misjudge range.
- Which SNaN gets quieted when both operands are NaNs.
- A clear colliding with a detection on the sticky flag.

// File: rtl/fpinv_pkg.sv
package fpinv_pkg;

    typedef enum logic [3:0] {
        OP_ADD       = 4'd0,
        OP_SUB       = 4'd1,
        OP_MUL       = 4'd2,
        OP_DIV       = 4'd3,
        OP_SQRT      = 4'd4,
        OP_REM       = 4'd5,
        OP_CMP_ORD   = 4'd6,
        OP_CMP_UNORD = 4'd7,
        OP_CVT       = 4'd8
    } fp_op_e;

    typedef enum logic [1:0] {
        OVR_NONE       = 2'd0,
        OVR_QNAN_INDEF = 2'd1,
        OVR_QUIET_SNAN = 2'd2,
        OVR_INT_INDEF  = 2'd3
    } ovr_e;

    typedef struct packed {
        logic sign;
        logic zero;
        logic sub;
        logic norm;
        logic inf;
        logic qnan;
        logic snan;
    } fcls_t;

    typedef enum logic {
        STK_IDLE = 1'b0,
        STK_SET  = 1'b1
    } stk_state_e;

endpackage

// File: rtl/fpinv_classify.sv
module fpinv_classify
    import fpinv_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic [W-1:0] x,
    output fcls_t        cls
);
    logic [EXP_W-1:0]  expf;
    logic [FRAC_W-1:0] frac;
    logic exp_ones, exp_zero, frac_zero;

    assign expf      = x[W-2:FRAC_W];
    assign frac      = x[FRAC_W-1:0];
    assign exp_ones  = &expf;
    assign exp_zero  = ~|expf;
    assign frac_zero = ~|frac;

    always_comb begin
        cls.sign = x[W-1];
        cls.zero = exp_zero & frac_zero;
        cls.sub  = exp_zero & ~frac_zero;
        cls.norm = ~exp_zero & ~exp_ones;
        cls.inf  = exp_ones & frac_zero;
        cls.qnan = exp_ones & frac[FRAC_W-1];
        cls.snan = exp_ones & ~frac[FRAC_W-1] & ~frac_zero;
    end
endmodule

// File: rtl/fpinv_rules.sv
module fpinv_rules
    import fpinv_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    parameter int INT_W  = 32,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  fcls_t        ac,
    input  fcls_t        bc,
    output logic         inv,
    output ovr_e         ovr,
    output logic [W-1:0] ovr_val,
    output logic [2:0]   cc
);
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;
    localparam logic [EXP_W-1:0] LIM_EXP = EXP_W'(BIAS + INT_W - 1);
    localparam logic [W-1:0] QNAN_INDEF = {1'b1, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [W-1:0] INT_INDEF  = W'(1) << (INT_W - 1);
    localparam logic [W-1:0] QUIET_BIT  = W'(1) << (FRAC_W - 1);
    localparam logic [2:0] CC_GT = 3'b000;
    localparam logic [2:0] CC_LT = 3'b001;
    localparam logic [2:0] CC_EQ = 3'b100;
    localparam logic [2:0] CC_UN = 3'b111;

    logic a_nan, b_nan, any_nan, any_snan;
    logic arith_bad, cvt_range, mag_gt, a_gt;
    logic [2:0] ord_cc;

    assign a_nan    = ac.qnan | ac.snan;
    assign b_nan    = bc.qnan | bc.snan;
    assign any_nan  = a_nan | b_nan;
    assign any_snan = ac.snan | bc.snan;

    // Magnitude-then-sign ordering for non-NaN operands
    assign mag_gt = a[W-2:0] > b[W-2:0];
    always_comb begin
        a_gt = ac.sign ? ~mag_gt : mag_gt;
        if ((ac.zero && bc.zero) || (a == b))
            ord_cc = CC_EQ;
        else if (ac.sign != bc.sign)
            ord_cc = ac.sign ? CC_LT : CC_GT;
        else
            ord_cc = a_gt ? CC_GT : CC_LT;
    end

    // Out of integer range: exponent at or above the limit, except -2^(INT_W-1)
    assign cvt_range = (a[W-2:FRAC_W] >= LIM_EXP) &&
                       !(ac.sign && (a[W-2:FRAC_W] == LIM_EXP) && ~|a[FRAC_W-1:0]);

    // Operand-value rules for the binary arithmetic classes (NaN-free case)
    always_comb begin
        arith_bad = 1'b0;
        case (op)
            OP_ADD:  arith_bad = ac.inf && bc.inf && (ac.sign != bc.sign);
            OP_SUB:  arith_bad = ac.inf && bc.inf && (ac.sign == bc.sign);
            OP_MUL:  arith_bad = (ac.inf && bc.zero) || (ac.zero && bc.inf);
            OP_DIV:  arith_bad = (ac.inf && bc.inf) || (ac.zero && bc.zero);
            OP_REM:  arith_bad = bc.zero || ac.inf;
            default: arith_bad = 1'b0;
        endcase
    end

    always_comb begin
        inv = 1'b0;
        ovr = OVR_NONE;
        cc  = 3'b000;
        case (op)
            OP_ADD, OP_SUB, OP_MUL, OP_DIV, OP_REM: begin
                if (any_snan) begin
                    inv = 1'b1;
                    ovr = OVR_QUIET_SNAN;
                end else if (!any_nan && arith_bad) begin
                    inv = 1'b1;
                    ovr = OVR_QNAN_INDEF;
                end
            end
            OP_SQRT: begin
                if (ac.snan) begin
                    inv = 1'b1;
                    ovr = OVR_QUIET_SNAN;
                end else if (ac.sign && !ac.zero && !a_nan) begin
                    inv = 1'b1;
                    ovr = OVR_QNAN_INDEF;
                end
            end
            OP_CMP_ORD: begin
                inv = any_nan;
                cc  = any_nan ? CC_UN : ord_cc;
            end
            OP_CMP_UNORD: begin
                inv = any_snan;
                cc  = any_nan ? CC_UN : ord_cc;
            end
            OP_CVT: begin
                if (a_nan || ac.inf || cvt_range) begin
                    inv = 1'b1;
                    ovr = OVR_INT_INDEF;
                end
            end
            default: begin
                inv = 1'b0;
            end
        endcase
    end

    always_comb begin
        unique case (ovr)
            OVR_NONE:       ovr_val = '0;
            OVR_QNAN_INDEF: ovr_val = QNAN_INDEF;
            OVR_QUIET_SNAN: ovr_val = (ac.snan ? a : b) | QUIET_BIT;
            OVR_INT_INDEF:  ovr_val = INT_INDEF;
        endcase
    end
endmodule

// File: rtl/fpinv_sticky.sv
module fpinv_sticky
    import fpinv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr,
    output logic sticky
);
    stk_state_e state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= STK_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt    = state;
        sticky = 1'b0;
        unique case (state)
            STK_IDLE: begin
                if (hit) nxt = STK_SET;              // SET_ON_HIT
            end
            STK_SET: begin
                sticky = 1'b1;
                if (clr && !hit) nxt = STK_IDLE;     // CLEAR
            end
        endcase
    end
endmodule

// File: rtl/fpinv_top.sv
module fpinv_top
    import fpinv_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    parameter int INT_W  = 32,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid_i,
    input  logic [3:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sticky_clr_i,
    output logic         valid_o,
    output logic         invalid_o,
    output logic [1:0]   ovr_o,
    output logic [W-1:0] ovr_val_o,
    output logic [2:0]   cc_o,
    output logic         sticky_o
);
    logic [W-1:0] opnd [2];
    fcls_t        cls  [2];
    logic         inv_c;
    ovr_e         ovr_c;
    logic [W-1:0] val_c;
    logic [2:0]   cc_c;

    assign opnd[0] = a_i;
    assign opnd[1] = b_i;

    for (genvar gi = 0; gi < 2; gi++) begin : g_cls
        fpinv_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .x   (opnd[gi]),
            .cls (cls[gi])
        );
    end

    fpinv_rules #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_rules (
        .op      (op_i),
        .a       (a_i),
        .b       (b_i),
        .ac      (cls[0]),
        .bc      (cls[1]),
        .inv     (inv_c),
        .ovr     (ovr_c),
        .ovr_val (val_c),
        .cc      (cc_c)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_o   <= 1'b0;
            invalid_o <= 1'b0;
            ovr_o     <= 2'd0;
            ovr_val_o <= '0;
            cc_o      <= 3'b000;
        end else begin
            valid_o <= valid_i;
            if (valid_i) begin
                invalid_o <= inv_c;
                ovr_o     <= ovr_c;
                ovr_val_o <= val_c;
                cc_o      <= cc_c;
            end
        end
    end

    fpinv_sticky u_sticky (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (valid_i & inv_c),
        .clr    (sticky_clr_i),
        .sticky (sticky_o)
    );
endmodule

// File: rtl/fpinv_chk.sv
module fpinv_chk #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    parameter int INT_W  = 32,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic         valid_i,
    input logic         sticky_clr_i,
    input logic         valid_o,
    input logic         invalid_o,
    input logic [1:0]   ovr_o,
    input logic [W-1:0] ovr_val_o,
    input logic [2:0]   cc_o,
    input logic         sticky_o
);
    localparam logic [W-1:0] QNAN_V = {1'b1, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [W-1:0] INT_V  = W'(1) << (INT_W - 1);

    AST_ONE_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o); // R1
    AST_QUIETED_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_o == 2'd2) |-> (invalid_o && ovr_val_o[FRAC_W-1])); // R2
    AST_QNAN_INDEF_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_o == 2'd1) |-> (invalid_o && ovr_val_o == QNAN_V)); // R3
    AST_UNORDERED_NO_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_o == 3'b111) |-> (ovr_o == 2'd0)); // R7
    AST_CC_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_o != 3'b111) |-> $onehot0(cc_o)); // R7
    AST_NONE_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_o == 2'd0) |-> (ovr_val_o == '0)); // R9
    AST_INT_INDEF_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_o == 2'd3) |-> (invalid_o && ovr_val_o == INT_V)); // R10
    AST_STICKY_CATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && invalid_o) |-> sticky_o); // R11
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_o && !sticky_clr_i) |=> sticky_o); // R11
endmodule

bind fpinv_top fpinv_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .valid_i      (valid_i),
    .sticky_clr_i (sticky_clr_i),
    .valid_o      (valid_o),
    .invalid_o    (invalid_o),
    .ovr_o        (ovr_o),
    .ovr_val_o    (ovr_val_o),
    .cc_o         (cc_o),
    .sticky_o     (sticky_o)
);

// File: tb/sim_fpinv_top.sv
`timescale 1ns/1ps
module sim_fpinv_top;
    typedef struct packed {
        logic [3:0]  req;
        logic [3:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic        inv;
        logic [1:0]  ovr;
        logic [31:0] val;
        logic [2:0]  cc;
    } vec_t;

    localparam int NV = 38;
    localparam vec_t VEC [NV] = '{
        '{4'd1,  4'd0, 32'h3F800000, 32'h40000000, 1'b0, 2'd0, 32'h00000000, 3'b000}, // R1 plain add
        '{4'd3,  4'd0, 32'h7F800000, 32'hFF800000, 1'b1, 2'd1, 32'hFFC00000, 3'b000}, // R3
        '{4'd3,  4'd0, 32'h7F800000, 32'h7F800000, 1'b0, 2'd0, 32'h00000000, 3'b000}, // R3
        '{4'd3,  4'd1, 32'h7F800000, 32'h7F800000, 1'b1, 2'd1, 32'hFFC00000, 3'b000}, // R3
        '{4'd3,  4'd1, 32'h7F800000, 32'hFF800000, 1'b0, 2'd0, 32'h00000000, 3'b000}, // R3
        '{4'd4,  4'd2, 32'h7F800000, 32'h00000000, 1'b1, 2'd1, 32'hFFC00000, 3'b000}, // R4
        '{4'd4,  4'd2, 32'h80000000, 32'hFF800000, 1'b1, 2'd1, 32'hFFC00000, 3'b000}, // R4
        '{4'd4,  4'd3, 32'h7F800000, 32'hFF800000, 1'b1, 2'd1, 32'hFFC00000, 3'b000}, // R4
        '{4'd4,  4'd3, 32'h00000000, 32'h80000000, 1'b1, 2'd1, 32'hFFC00000, 3'b000}, // R4
        '{4'd4,  4'd3, 32'h3F800000, 32'h00000000, 1'b0, 2'd0, 32'h00000000, 3'b000}, // R4
        '{4'd4,  4'd2, 32'h00000001, 32'h7F800000, 1'b0, 2'd0, 32'h00000000, 3'b000}, // R4 subnormal
        '{4'd2,  4'd0, 32'h7F800001, 32'h3F800000, 1'b1, 2'd2, 32'h7FC00001, 3'b000}, // R2
        '{4'd2,  4'd2, 32'h3F800000, 32'hFF812345, 1'b1, 2'd2, 32'hFFC12345, 3'b000}, // R2
        '{4'd2,  4'd0, 32'h7FC00000, 32'h7F800001, 1'b1, 2'd2, 32'h7FC00001, 3'b000}, // R2
        '{4'd2,  4'd1, 32'h7F800005, 32'hFF800007, 1'b1, 2'd2, 32'h7FC00005, 3'b000}, // R2 a first
        '{4'd9,  4'd0, 32'h7FC00000, 32'h3F800000, 1'b0, 2'd0, 32'h00000000, 3'b000}, // R9
        '{4'd9,  4'd5, 32'h3F800000, 32'hFFC00000, 1'b0, 2'd0, 32'h00000000, 3'b000}, // R9
        '{4'd5,  4'd4, 32'hBF800000, 32'h00000000, 1'b1, 2'd1, 32'hFFC00000, 3'b000}, // R5
        '{4'd5,  4'd4, 32'h80000000, 32'h7F800001, 1'b0, 2'd0, 32'h00000000, 3'b000}, // R5
        '{4'd5,  4'd4, 32'hFF800000, 32'h00000000, 1'b1, 2'd1, 32'hFFC00000, 3'b000}, // R5
        '{4'd6,  4'd5, 32'h3F800000, 32'h00000000, 1'b1, 2'd1, 32'hFFC00000, 3'b000}, // R6
        '{4'd6,  4'd5, 32'h7F800000, 32'h3F800000, 1'b1, 2'd1, 32'hFFC00000, 3'b000}, // R6
        '{4'd6,  4'd5, 32'h3F800000, 32'h7F800000, 1'b0, 2'd0, 32'h00000000, 3'b000}, // R6
        '{4'd7,  4'd6, 32'h3F800000, 32'h40000000, 1'b0, 2'd0, 32'h00000000, 3'b001}, // R7
        '{4'd7,  4'd6, 32'h40000000, 32'h3F800000, 1'b0, 2'd0, 32'h00000000, 3'b000}, // R7
        '{4'd7,  4'd6, 32'h00000000, 32'h80000000, 1'b0, 2'd0, 32'h00000000, 3'b100}, // R7
        '{4'd7,  4'd6, 32'hC0000000, 32'hBF800000, 1'b0, 2'd0, 32'h00000000, 3'b001}, // R7
        '{4'd7,  4'd6, 32'h7FC00000, 32'h3F800000, 1'b1, 2'd0, 32'h00000000, 3'b111}, // R7
        '{4'd8,  4'd7, 32'h7FC00000, 32'h3F800000, 1'b0, 2'd0, 32'h00000000, 3'b111}, // R8
        '{4'd8,  4'd7, 32'h3F800000, 32'h7F800001, 1'b1, 2'd0, 32'h00000000, 3'b111}, // R8
        '{4'd8,  4'd7, 32'h7F800000, 32'h3F800000, 1'b0, 2'd0, 32'h00000000, 3'b000}, // R8
        '{4'd10, 4'd8, 32'h3F800000, 32'h00000000, 1'b0, 2'd0, 32'h00000000, 3'b000}, // R10
        '{4'd10, 4'd8, 32'h4F000000, 32'h00000000, 1'b1, 2'd3, 32'h80000000, 3'b000}, // R10
        '{4'd10, 4'd8, 32'hCF000000, 32'h00000000, 1'b0, 2'd0, 32'h00000000, 3'b000}, // R10
        '{4'd10, 4'd8, 32'h4EFFFFFF, 32'h00000000, 1'b0, 2'd0, 32'h00000000, 3'b000}, // R10
        '{4'd10, 4'd8, 32'h7F800001, 32'h00000000, 1'b1, 2'd3, 32'h80000000, 3'b000}, // R10
        '{4'd10, 4'd8, 32'hFF800000, 32'h7F800001, 1'b1, 2'd3, 32'h80000000, 3'b000}, // R10
        '{4'd12, 4'd9, 32'h7F800001, 32'h7FC00000, 1'b0, 2'd0, 32'h00000000, 3'b000}  // R12
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [3:0]  op_i = '0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic        sticky_clr_i = 1'b0;
    logic        valid_o, invalid_o, sticky_o;
    logic [1:0]  ovr_o;
    logic [31:0] ovr_val_o;
    logic [2:0]  cc_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    fpinv_top u0 (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .sticky_clr_i(sticky_clr_i), .valid_o(valid_o), .invalid_o(invalid_o),
        .ovr_o(ovr_o), .ovr_val_o(ovr_val_o), .cc_o(cc_o), .sticky_o(sticky_o)
    );

    task automatic chk(input int r, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s actual=%h expected=%h", r, what, act, exp);
        end
    endtask

    task automatic apply(input logic v, input logic clr, input logic [3:0] op,
                         input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        valid_i = v; sticky_clr_i = clr; op_i = op; a_i = a; b_i = b;
        @(negedge clk);
        valid_i = 1'b0; sticky_clr_i = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL R1 watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(12, "reset valid_o", {31'd0, valid_o}, 32'd0);
        chk(12, "reset invalid_o", {31'd0, invalid_o}, 32'd0);
        chk(12, "reset ovr_val_o", ovr_val_o, 32'd0);
        chk(12, "reset sticky_o", {31'd0, sticky_o}, 32'd0);
        rst_n = 1'b1;

        // R1 latency: nothing before the edge, result one edge later, gone after
        @(negedge clk);
        valid_i = 1'b1; op_i = 4'd0; a_i = 32'h7F800000; b_i = 32'hFF800000;
        #1 chk(1, "valid_o before edge", {31'd0, valid_o}, 32'd0);
        @(negedge clk);
        valid_i = 1'b0;
        chk(1, "valid_o after edge", {31'd0, valid_o}, 32'd1);
        chk(1, "invalid_o after edge", {31'd0, invalid_o}, 32'd1);
        @(negedge clk);
        chk(1, "valid_o drops", {31'd0, valid_o}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            apply(1'b1, 1'b0, VEC[i].op, VEC[i].a, VEC[i].b);
            chk(int'(VEC[i].req), $sformatf("vec%0d invalid", i), {31'd0, invalid_o}, {31'd0, VEC[i].inv});
            chk(int'(VEC[i].req), $sformatf("vec%0d ovr", i), {30'd0, ovr_o}, {30'd0, VEC[i].ovr});
            chk(int'(VEC[i].req), $sformatf("vec%0d value", i), ovr_val_o, VEC[i].val);
            chk(int'(VEC[i].req), $sformatf("vec%0d cc", i), {29'd0, cc_o}, {29'd0, VEC[i].cc});
        end

        // R11 sticky behaviour
        chk(11, "sticky after table", {31'd0, sticky_o}, 32'd1);
        apply(1'b0, 1'b1, 4'd0, 32'h0, 32'h0);
        chk(11, "sticky cleared", {31'd0, sticky_o}, 32'd0);
        apply(1'b1, 1'b1, 4'd3, 32'h0, 32'h0);
        chk(11, "clear with hit keeps set", {31'd0, sticky_o}, 32'd1);
        apply(1'b1, 1'b0, 4'd0, 32'h3F800000, 32'h3F800000);
        chk(11, "sticky holds on clean op", {31'd0, sticky_o}, 32'd1);
        chk(11, "clean op not invalid", {31'd0, invalid_o}, 32'd0);
        apply(1'b0, 1'b1, 4'd0, 32'h0, 32'h0);
        // R1 no effect while valid_i is low
        apply(1'b0, 1'b0, 4'd0, 32'h7F800000, 32'hFF800000);
        chk(1, "idle invalid input: sticky", {31'd0, sticky_o}, 32'd0);
        chk(1, "idle invalid input: invalid_o held", {31'd0, invalid_o}, 32'd0);
        chk(1, "idle invalid input: valid_o", {31'd0, valid_o}, 32'd0);
        // R12 undefined code
        apply(1'b1, 1'b0, 4'd15, 32'hFF800000, 32'h7F800001);
        chk(12, "op 15 invalid", {31'd0, invalid_o}, 32'd0);
        chk(12, "op 15 sticky", {31'd0, sticky_o}, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule